// File: doc/BRIEF.md
# System Control Port with Refresh Toggle

This block is a one-byte system control register that sits beside an interval timer. A byte write sets two control bits. One bit drives the gate input of timer channel 2. The other enables speaker data, which passes the channel 2 output on to a speaker pin. A byte read returns those two bits, the present level of the channel 2 output, and a status bit that toggles by itself at a fixed period of about 15 µs. Software polls that status bit for coarse delay loops.

The toggle bit comes from a free-running divider. `REFRESH_CYCLES` sets its half period in system clock cycles. The default of 1509 suits a 100 MHz clock and gives about 15.09 µs. A small state machine with two named states, `PH_LOW` and `PH_HIGH`, holds the toggle level. The transition `PH_LOW -> PH_HIGH` and the transition `PH_HIGH -> PH_LOW` are each taken only when the divider wraps. In every other cycle the machine holds its state. Writes never touch the divider or the state machine.

Top module: `sysctl_port`

## Requirements
- R1: After reset, `t2_gate` is 0, `spkr_out` is 0 and `rd_data` is 0 while `t2_out` is 0. Here read bit 0 is the gate, bit 1 is the speaker enable, bit 4 is the toggle and bit 5 is the channel 2 output.
- R2: A clock edge with `wr_en` high loads `wr_data[0]` into the channel 2 gate. The new value appears on `t2_gate` and on read bit 0 after that edge.
- R3: A clock edge with `wr_en` high loads `wr_data[1]` into the speaker enable. The new value appears on read bit 1 after that edge.
- R4: While `wr_en` is low, a change on `wr_data` does not alter `t2_gate` or read bits 0 and 1.
- R5: Read bit 5 follows `t2_out` in the same cycle, with no register on the path.
- R6: Read bits 2, 3, 6 and 7 are always 0. Writing ones to `wr_data` bits 2 to 7 has no visible effect.
- R7: Read bit 4 starts at 0 after reset and inverts on every `REFRESH_CYCLES`-th rising clock edge after reset is released. It therefore holds each level for exactly `REFRESH_CYCLES` cycles.
- R8: `spkr_out` equals `t2_out` AND the speaker enable, combinationally.
- R9: A write in the same cycle as a toggle edge takes full effect, and the toggle phase is not shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte (bit 0 gate, bit 1 speaker enable) |
| t2_out | input | 1 | Output level of timer channel 2 |
| rd_data | output | 8 | Status byte |
| t2_gate | output | 1 | Gate drive to timer channel 2 |
| spkr_out | output | 1 | Channel 2 output gated by speaker enable |

## Verification
A control write and a toggle of the refresh bit can land on the same clock edge. The bench tracks the toggle phase with its own edge counter. It places a write whose capture edge is exactly a divider wrap. It then checks that read bits 0 and 1 and read bit 4 all change together, and that later toggles keep the original spacing. A second overlap is a change of `t2_out` in the same cycle as a write to the speaker enable. This is judged on `spkr_out` and read bit 5 before and after the capture edge.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } ref_phase_e;

    localparam int BIT_GATE  = 0;
    localparam int BIT_SPKEN = 1;
    localparam int BIT_TOGL  = 4;
    localparam int BIT_T2OUT = 5;
    localparam int BYTE_W    = 8;

endpackage

// File: rtl/sysctl_refresh_div.sv
module sysctl_refresh_div
    import sysctl_pkg::*;
#(
    parameter int REFRESH_CYCLES = 1509
) (
    input  logic clk,
    input  logic rst_n,
    output logic toggle
);
    localparam int CNT_W = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    ref_phase_e       state_q, state_d;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (wrap) state_d = PH_HIGH;
            PH_HIGH: if (wrap) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    always_comb toggle = (state_q == PH_HIGH);

    // R7
    toggle_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle != $past(toggle)) |-> ($past(cnt_q) == LAST));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              gate,
    output logic              spk_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate   <= 1'b0;
            spk_en <= 1'b0;
        end else if (wr_en) begin
            gate   <= wr_data[BIT_GATE];
            spk_en <= wr_data[BIT_SPKEN];
        end
    end

    // R2
    gate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (gate == $past(wr_data[BIT_GATE])));

    // R3
    spken_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (spk_en == $past(wr_data[BIT_SPKEN])));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(gate) && $stable(spk_en)));

endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
(
    input  logic              gate,
    input  logic              spk_en,
    input  logic              toggle,
    input  logic              t2_out,
    output logic [BYTE_W-1:0] rd_data
);
    always_comb begin
        rd_data            = '0;
        rd_data[BIT_GATE]  = gate;
        rd_data[BIT_SPKEN] = spk_en;
        rd_data[BIT_TOGL]  = toggle;
        rd_data[BIT_T2OUT] = t2_out;
    end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int REFRESH_CYCLES = 1509
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       t2_out,
    output logic [7:0] rd_data,
    output logic       t2_gate,
    output logic       spkr_out
);
    logic gate, spk_en, toggle;

    sysctl_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .gate    (gate),
        .spk_en  (spk_en)
    );

    sysctl_refresh_div #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (toggle)
    );

    sysctl_read_mux u_mux (
        .gate    (gate),
        .spk_en  (spk_en),
        .toggle  (toggle),
        .t2_out  (t2_out),
        .rd_data (rd_data)
    );

    assign t2_gate  = gate;
    assign spkr_out = t2_out & spk_en;

    // R5
    t2_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_T2OUT] == t2_out);

    // R8
    spkr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out |-> (t2_out && rd_data[BIT_SPKEN]));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] == 2'b00) && (rd_data[3:2] == 2'b00));

endmodule

// File: tb/sim_sysctl_port.sv
module sim_sysctl_port;
    localparam int CLK_PERIOD = 10;
    localparam int NDIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       t2_out = 1'b0;
    logic [7:0] rd_data;
    logic       t2_gate, spkr_out;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    sysctl_port #(.REFRESH_CYCLES(NDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .t2_out(t2_out), .rd_data(rd_data), .t2_gate(t2_gate), .spkr_out(spkr_out)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic int exp_tog();
        return (ecnt / NDIV) % 2;
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        check("R1 rd_data", rd_data, 0);
        check("R1 t2_gate", t2_gate, 0);
        check("R1 spkr_out", spkr_out, 0);
    endtask

    task automatic t_write_bits();
        write_byte(8'h01);
        // R2
        check("R2 gate pin", t2_gate, 1);
        check("R2 rd bit0", rd_data[0], 1);
        check("R3 rd bit1 clear", rd_data[1], 0);
        write_byte(8'h02);
        check("R2 gate cleared", t2_gate, 0);
        // R3
        check("R3 rd bit1", rd_data[1], 1);
        write_byte(8'h03);
        check("R3 both set", rd_data[1:0], 3);
    endtask

    task automatic t_ignore_idle();
        @(negedge clk);
        wr_data = 8'h00;
        repeat (3) @(negedge clk);
        // R4
        check("R4 gate held", t2_gate, 1);
        check("R4 bits held", rd_data[1:0], 3);
    endtask

    task automatic t_reserved();
        write_byte(8'hFC);
        // R6
        check("R6 reserved bits", {rd_data[7:6], rd_data[3:2]}, 0);
        check("R6 ctrl bits cleared", rd_data[1:0], 0);
        check("R6 gate", t2_gate, 0);
    endtask

    task automatic t_mirror_and_speaker();
        write_byte(8'h02);
        @(negedge clk);
        t2_out = 1'b1;
        #1;
        // R5
        check("R5 bit5 high", rd_data[5], 1);
        // R8
        check("R8 spkr on", spkr_out, 1);
        t2_out = 1'b0;
        #1;
        check("R5 bit5 low", rd_data[5], 0);
        check("R8 spkr follows", spkr_out, 0);
        // t2_out rises in the same cycle a write clears the enable
        @(negedge clk);
        t2_out = 1'b1;
        wr_data = 8'h00;
        wr_en = 1'b1;
        #1;
        check("R8 before capture", spkr_out, 1);
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 after disable", spkr_out, 0);
        check("R5 still mirrors", rd_data[5], 1);
        t2_out = 1'b0;
    endtask

    task automatic t_refresh();
        for (int i = 0; i < 4 * NDIV; i++) begin
            @(negedge clk);
            // R7
            check("R7 toggle level", rd_data[4], exp_tog());
        end
    endtask

    task automatic t_write_on_toggle();
        // align so the capture edge is a divider wrap
        while (((ecnt + 1) % NDIV) != 0) @(negedge clk);
        wr_data = 8'h03;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        // R9
        check("R9 write taken", rd_data[1:0], 3);
        check("R9 toggle taken", rd_data[4], exp_tog());
        for (int i = 0; i < 2 * NDIV; i++) begin
            @(negedge clk);
            check("R9 phase kept", rd_data[4], exp_tog());
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 starts low", rd_data[4], 0);
        t_write_bits();
        t_ignore_idle();
        t_reserved();
        t_mirror_and_speaker();
        t_refresh();
        t_write_on_toggle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule